// File: doc/BRIEF.md
# Byte-Wide Selectable CRC Engine

This block keeps a running cyclic redundancy checksum over a message of any length. The message arrives one byte at a time through a small write port. Each accepted data byte is folded into the checksum within one clock cycle. A mode register selects one of three fixed generator polynomials: one of width 8 and two of width 16. The same register chooses whether each byte is folded in starting from its most significant bit or from its least significant bit. This lets the result match a serial link that sends either end of a byte first.

Software, or a neighbouring block, uses one write port with three addresses. A mode write sets up the computation and zeroes the checksum. A seed write loads a starting value. A data write folds in one byte. The checksum can be read at any time on a dedicated output. Changing the polynomial always goes through a mode write, so a checksum is never carried from one polynomial into another.

Top module: `byte_crc_engine`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), crc_out is 0, the polynomial select is 0 and the mode is MSB-first.
- R2: A write to address 0 takes wr_data[1:0] as the polynomial select and wr_data[2] as the bit order (1 = LSB-first). The select codes are 0 for x^8+x^2+x+1, 1 for x^16+x^15+x^2+1 and 2 for x^16+x^12+x^5+1. After the next clock edge, crc_out is 0.
- R3: A write to address 0 with select code 3 is ignored. It changes neither the mode nor the checksum, and later bytes are processed in the previous mode.
- R4: A write to address 1 folds wr_data[7:0] into the checksum. The new value appears on crc_out after that same clock edge, so consecutive bytes may be written on back-to-back cycles.
- R5: In MSB-first mode, byte bit 7 is processed first, using the polynomial in its normal bit order. For the 8-bit polynomial, the checksum sits in crc_out[7:0].
- R6: In LSB-first mode, byte bit 0 is processed first, using the bit-reversed polynomial. The checksum is presented as computed, with no final reversal.
- R7: A write to address 2 loads the checksum from wr_data. With the 8-bit polynomial, only wr_data[7:0] is kept.
- R8: While the 8-bit polynomial is selected, crc_out[15:8] is always 0.
- R9: With wr_en low, or on a write to address 3, the checksum holds its value.
- R10: Starting from zero, the ASCII string "123456789" yields the following results:
  - 0xF4 for select 0, MSB-first;
  - 0xFEE8 for select 1, MSB-first;
  - 0xBB3D for select 1, LSB-first;
  - 0x31C3 for select 2, MSB-first;
  - 0x2189 for select 2, LSB-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | 0 mode, 1 data byte, 2 seed, 3 unused |
| wr_data | input | 16 | Write data |
| crc_out | output | 16 | Current checksum |

## Verification
Several behaviours are checked by assertions on every cycle:
- the checksum is zeroed after an accepted mode write;
- the mode holds after a write with the reserved select;
- the checksum holds while no write is made;
- the upper byte stays at zero in 8-bit mode;
- a seed write loads the seed value.

The polynomial arithmetic itself can only be shown by the bench's scenarios. These scenarios cover the known check strings in each mode and long pseudo-random byte streams compared against a bit-serial reference model. The same applies to the bit order of each mode, to mid-stream seeding and to a reset in the middle of a message.

// File: rtl/crc_pkg.sv
// Package: shared constants, types and polynomial helpers for the byte CRC engine.
// Assumes the data width is smaller than the checksum width.
package crc_pkg;
    localparam int DATA_W   = 8;
    localparam int CRC_W    = 16;
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        POLY_C8  = 2'd0,   // x^8 + x^2 + x + 1
        POLY_A16 = 2'd1,   // x^16 + x^15 + x^2 + 1
        POLY_B16 = 2'd2,   // x^16 + x^12 + x^5 + 1
        POLY_RSV = 2'd3    // reserved, rejected
    } poly_sel_e;

    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_SEED = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        poly_sel_e sel;
        logic      lsb_first;
    } crc_mode_t;

    // Tap pattern (without the leading term) of each polynomial, right aligned.
    function automatic logic [CRC_W-1:0] poly_taps(input poly_sel_e s);
        logic [CRC_W-1:0] t;
        case (s)
            POLY_C8:  t = CRC_W'(16'h0007);
            POLY_A16: t = CRC_W'(16'h8005);
            POLY_B16: t = CRC_W'(16'h1021);
            default:  t = '0;
        endcase
        return t;
    endfunction

    // Full-width bit reversal.
    function automatic logic [CRC_W-1:0] reverse_bits(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) begin
            r[CRC_W-1-i] = v[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/crc_mode_reg.sv
// Module: holds the polynomial select and bit order, and derives the tap
// vectors for both shift directions. Assumes one write strobe per cycle.
// A write with the reserved select code is dropped entirely.
module crc_mode_reg
    import crc_pkg::*;
#(
    parameter int CW = CRC_W,
    parameter int NW = NARROW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_we,
    input  logic [2:0]      mode_wdata,
    output crc_mode_t       mode_q,
    output logic            clear_req,
    output logic            narrow,
    output logic [CW-1:0]   taps_msb,
    output logic [CW-1:0]   taps_lsb
);
    localparam int ALIGN = CW - NW;

    poly_sel_e        req_sel;
    logic             accept;
    logic [CW-1:0]    taps_raw;
    logic [CW-1:0]    taps_rev;

    // Purpose: decode the requested select and decide whether to accept it.
    always_comb begin
        req_sel = poly_sel_e'(mode_wdata[1:0]);
        accept  = mode_we && (req_sel != POLY_RSV);
    end

    // Purpose: mode register, reset to the 8-bit polynomial and MSB-first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.sel       <= POLY_C8;
            mode_q.lsb_first <= 1'b0;
        end else if (accept) begin
            mode_q.sel       <= req_sel;
            mode_q.lsb_first <= mode_wdata[2];
        end
    end

    // Purpose: derive tap vectors aligned for each shift direction.
    always_comb begin
        narrow    = (mode_q.sel == POLY_C8);
        taps_raw  = poly_taps(mode_q.sel);
        taps_rev  = reverse_bits(taps_raw);
        taps_msb  = narrow ? (taps_raw << ALIGN) : taps_raw;
        taps_lsb  = narrow ? (taps_rev >> ALIGN) : taps_rev;
        clear_req = accept;
    end

    // R3
    rsv_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata[1:0] == 2'b11) |=> $stable({mode_q.sel, mode_q.lsb_first}));
endmodule

// File: rtl/crc_byte_step.sv
// Module: combinational fold of one data byte into the checksum, unrolled
// over all data bits, for both shift directions. A narrow checksum is
// left-aligned for the MSB-first path and kept right-aligned for LSB-first.
// Assumes DW < CW.
module crc_byte_step
    import crc_pkg::*;
#(
    parameter int CW = CRC_W,
    parameter int DW = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic [CW-1:0] cur,
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] taps_msb,
    input  logic [CW-1:0] taps_lsb,
    input  logic          narrow,
    input  logic          lsb_first,
    output logic [CW-1:0] nxt
);
    localparam int PAD   = CW - DW;
    localparam int ALIGN = CW - NW;

    logic [CW-1:0] msb_chain [DW+1];
    logic [CW-1:0] lsb_chain [DW+1];
    logic [CW-1:0] cur_left;
    logic [CW-1:0] msb_res;

    assign cur_left     = narrow ? (cur << ALIGN) : cur;
    assign msb_chain[0] = cur_left ^ {din, {PAD{1'b0}}};
    assign lsb_chain[0] = cur ^ {{PAD{1'b0}}, din};

    // One shift stage per data bit in each direction.
    for (genvar b = 0; b < DW; b++) begin : g_stage
        assign msb_chain[b+1] = msb_chain[b][CW-1] ? ((msb_chain[b] << 1) ^ taps_msb)
                                                   :  (msb_chain[b] << 1);
        assign lsb_chain[b+1] = lsb_chain[b][0]    ? ((lsb_chain[b] >> 1) ^ taps_lsb)
                                                   :  (lsb_chain[b] >> 1);
    end

    // Purpose: realign the MSB-first result and pick the active direction.
    always_comb begin
        msb_res = narrow ? (msb_chain[DW] >> ALIGN) : msb_chain[DW];
        nxt     = lsb_first ? lsb_chain[DW] : msb_res;
    end
endmodule

// File: rtl/crc_accum.sv
// Module: the checksum register. Priority is clear, then seed, then byte update.
// Assumes at most one of the three requests per cycle (address decoded).
module crc_accum
    import crc_pkg::*;
#(
    parameter int CW = CRC_W,
    parameter int NW = NARROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_req,
    input  logic          seed_we,
    input  logic [CW-1:0] seed_val,
    input  logic          upd_we,
    input  logic [CW-1:0] upd_val,
    input  logic          narrow,
    output logic [CW-1:0] crc_q
);
    logic [CW-1:0] seed_masked;

    // Purpose: keep only the low bits of a seed in narrow mode.
    always_comb begin
        seed_masked = narrow ? {{(CW-NW){1'b0}}, seed_val[NW-1:0]} : seed_val;
    end

    // Purpose: update the running checksum.
    always_ff @(posedge clk) begin
        if (!rst_n)          crc_q <= '0;
        else if (clear_req)  crc_q <= '0;
        else if (seed_we)    crc_q <= seed_masked;
        else if (upd_we)     crc_q <= upd_val;
    end

    // R8
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (crc_q[CW-1:NW] == '0));

    // R7
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && !clear_req && !narrow) |=> (crc_q == $past(seed_val)));
endmodule

// File: rtl/byte_crc_engine.sv
// Module: top of the byte CRC engine. Decodes the write port into mode,
// data and seed requests, and ties the mode register, the byte step and
// the checksum register together. Assumes a single write per cycle.
module byte_crc_engine
    import crc_pkg::*;
#(
    parameter int CW = CRC_W,
    parameter int DW = DATA_W,
    parameter int NW = NARROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] crc_out
);
    logic          mode_we, data_we, seed_we;
    crc_mode_t     mode_q;
    logic          clear_req;
    logic          narrow;
    logic [CW-1:0] taps_msb, taps_lsb;
    logic [CW-1:0] step_nxt;
    logic [CW-1:0] crc_q;

    // Purpose: address decode of the write port.
    always_comb begin
        mode_we = wr_en && (reg_addr_e'(wr_addr) == ADDR_MODE);
        data_we = wr_en && (reg_addr_e'(wr_addr) == ADDR_DATA);
        seed_we = wr_en && (reg_addr_e'(wr_addr) == ADDR_SEED);
    end

    crc_mode_reg #(.CW(CW), .NW(NW)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (wr_data[2:0]),
        .mode_q     (mode_q),
        .clear_req  (clear_req),
        .narrow     (narrow),
        .taps_msb   (taps_msb),
        .taps_lsb   (taps_lsb)
    );

    crc_byte_step #(.CW(CW), .DW(DW), .NW(NW)) u_step (
        .cur        (crc_q),
        .din        (wr_data[DW-1:0]),
        .taps_msb   (taps_msb),
        .taps_lsb   (taps_lsb),
        .narrow     (narrow),
        .lsb_first  (mode_q.lsb_first),
        .nxt        (step_nxt)
    );

    crc_accum #(.CW(CW), .NW(NW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_req  (clear_req),
        .seed_we    (seed_we),
        .seed_val   (wr_data),
        .upd_we     (data_we),
        .upd_val    (step_nxt),
        .narrow     (narrow),
        .crc_q      (crc_q)
    );

    assign crc_out = crc_q;

    // R2
    mode_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[1:0] != 2'b11) |=> (crc_out == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == 2'd3) |=> $stable(crc_out));
endmodule

// File: tb/sim_byte_crc_engine.sv
module sim_byte_crc_engine;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] crc_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    logic [15:0] m_crc = 16'h0;
    int          m_sel = 0;
    bit          m_lsb = 1'b0;

    byte_crc_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .crc_out(crc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-serial reference built from the requirement text.
    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b,
                                             input int sel, input bit lsb);
        int w;
        logic [15:0] p, rp, mask;
        logic [15:0] r;
        logic fb;
        w    = (sel == 0) ? 8 : 16;
        p    = (sel == 0) ? 16'h0007 : (sel == 1) ? 16'h8005 : 16'h1021;
        mask = (sel == 0) ? 16'h00FF : 16'hFFFF;
        rp   = 16'h0;
        for (int i = 0; i < w; i++) rp[w-1-i] = p[i];
        r = c;
        if (lsb) begin
            for (int i = 0; i < 8; i++) begin
                fb = r[0] ^ b[i];
                r  = r >> 1;
                if (fb) r = r ^ rp;
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                fb = r[w-1] ^ b[i];
                r  = (r << 1) & mask;
                if (fb) r = r ^ p;
            end
        end
        return r;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: one write cycle, then queue the expected checksum.
    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input int sel, input bit lsb, input string tag);
        bus_write(2'd0, {13'h0, lsb, 2'(sel)});
        if (sel != 3) begin
            m_sel = sel;
            m_lsb = lsb;
            m_crc = 16'h0;
        end
        push(m_crc, tag);
    endtask

    task automatic put_byte(input logic [7:0] b, input string tag);
        bus_write(2'd1, {8'hA5, b});
        m_crc = ref_step(m_crc, b, m_sel, m_lsb);
        push(m_crc, tag);
    endtask

    task automatic put_seed(input logic [15:0] v, input string tag);
        bus_write(2'd2, v);
        m_crc = (m_sel == 0) ? {8'h00, v[7:0]} : v;
        push(m_crc, tag);
    endtask

    task automatic idle_cycle(input logic [15:0] v, input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        push(v, tag);
    endtask

    task automatic check_string(input int sel, input bit lsb, input logic [15:0] lit);
        string s = "123456789";
        set_mode(sel, lsb, "R2 mode write clears");
        for (int i = 0; i < s.len(); i++) put_byte(s[i], lsb ? "R6 lsb byte" : "R5 msb byte");
        idle_cycle(lit, "R10 check value");
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: pop and compare once the design has produced the result.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(crc_out, e.val, e.tag);
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle_cycle(16'h0, "R1 reset value");

        // R1: reset mode is the 8-bit polynomial, MSB-first
        put_byte(8'h31, "R1 reset mode byte");

        // R10 known vectors in each mode
        check_string(0, 1'b0, 16'h00F4);
        check_string(1, 1'b0, 16'hFEE8);
        check_string(1, 1'b1, 16'hBB3D);
        check_string(2, 1'b0, 16'h31C3);
        check_string(2, 1'b1, 16'h2189);

        // R3: reserved select ignored, mode kept (LSB-first select 2)
        put_byte(8'h5A, "R3 before reserved");
        set_mode(3, 1'b0, "R3 reserved select ignored");
        put_byte(8'hC3, "R3 old mode kept");

        // R9: idle and unused address hold
        idle_cycle(m_crc, "R9 idle hold");
        bus_write(2'd3, 16'hFFFF);
        push(m_crc, "R9 unused address hold");

        // R7 / R8: seeding wide and narrow
        set_mode(1, 1'b0, "R2 mode write clears");
        put_seed(16'hBEEF, "R7 wide seed");
        put_byte(8'h00, "R4 byte after seed");
        put_byte(8'hFF, "R4 back-to-back byte");
        set_mode(0, 1'b1, "R2 mode write clears");
        put_seed(16'hABCD, "R8 narrow seed upper zero");
        put_byte(8'h80, "R8 narrow lsb byte");

        // R5 / R6: pseudo-random streams in every mode
        for (int sel = 0; sel < 3; sel++) begin
            for (int o = 0; o < 2; o++) begin
                set_mode(sel, o[0], "R2 mode write clears");
                for (int k = 0; k < 40; k++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    put_byte(lfsr[7:0], o[0] ? "R6 lsb stream" : "R5 msb stream");
                end
            end
        end

        // R1: reset in mid-message
        set_mode(2, 1'b1, "R2 mode write clears");
        put_byte(8'h77, "R4 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_crc = 16'h0;
        m_sel = 0;
        m_lsb = 1'b0;
        push(m_crc, "R1 mid-run reset");
        put_byte(8'h77, "R1 mode after reset");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule